// File: doc/BRIEF.md
# Strap-then-drive mode/suspend pin controller

This block owns one bidirectional pad that serves two purposes one after the other. Right after reset is released the pad stays an input. At the end of a short window the block latches the level on the pad as a configuration strap that picks gang or individual power mode. The strap goes through a two-flop synchronizer before it is latched. The latched mode is then held until the next reset and goes to the power-control logic.

Much later, after a longer settling interval, the block enables the pad driver. From then on the pad reports whether the hub is in global suspend. The polarity of that flag follows the strapped mode, so the external pull resistor and the LED on the pin keep a consistent sense.

Both intervals are set in microseconds and are turned into clock cycles from a clock-frequency parameter. The pins are plain control and status signals; there is no data stream.

Top module: `strap_pin_ctrl`

## Requirements
- R1: While `rst_n` is low, `pad_oe`, `pad_out` and `gang_mode` are all 0.
- R2: The strap is taken at the STRAP_CYC-th rising clock edge after reset release (STRAP_CYC = CLK_KHZ*STRAP_US/1000). Because of the two-flop synchronizer, the latched value is the pad level present at edge STRAP_CYC-2. Earlier pad levels inside the window have no effect.
- R3: `gang_mode` is 0 before the strap is latched. After that it equals the latched pad level: 1 selects gang mode and 0 selects individual mode.
- R4: Once latched, `gang_mode` does not change until the next reset, whatever `pad_in` does.
- R5: `pad_oe` rises at exactly the DRIVE_CYC-th rising edge after reset release (DRIVE_CYC = CLK_KHZ*DRIVE_US/1000) and stays 1 until reset.
- R6: While `pad_oe` is 0, `pad_out` is 0.
- R7: In gang mode, once `pad_oe` is 1, `pad_out` equals `suspend_i` as sampled at the previous rising edge: 0 when the hub is running and 1 when it is suspended.
- R8: In individual mode, once `pad_oe` is 1, `pad_out` is the inverse of `suspend_i` as sampled at the previous rising edge: 1 when running and 0 when suspended.
- R9: Asserting reset during the drive phase returns the pad to input at once. The next release repeats the whole sequence and may latch a different strap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock at CLK_KHZ kHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | 1 | Level seen at the pad (strap source) |
| suspend_i | input | 1 | Global suspend state of the hub, 1 = suspended |
| pad_oe | output | 1 | Pad driver enable, 1 = drive |
| pad_out | output | 1 | Value driven onto the pad when enabled |
| gang_mode | output | 1 | Latched mode, 1 = gang, 0 = individual |

## Verification
The bench moves the strap edge to just before and just after the synchronizer's sampling point. A design with the wrong sampling point or the wrong synchronizer depth latches the wrong mode in one of the two cases. It checks the driver enable at one edge before the drive point and again at the drive point, which catches an off-by-one in the interval count. It sweeps every suspend pattern of a short sequence in both modes, so a swapped polarity or a missing output register shows up as a mismatch. It also toggles the pad after the strap and applies reset mid-drive: a design that relatches late, or that keeps driving during reset, fails there.

// File: rtl/strap_pin_pkg.sv
package strap_pin_pkg;
  typedef enum logic [1:0] {
    PH_STRAP = 2'd0,
    PH_HOLD  = 2'd1,
    PH_DRIVE = 2'd2
  } pin_phase_e;

  function automatic int unsigned us_to_cycles(input int unsigned khz, input int unsigned us);
    return (khz * us) / 1000;
  endfunction
endpackage

// File: rtl/strap_phase_timer.sv
module strap_phase_timer
  import strap_pin_pkg::*;
#(
  parameter int unsigned STRAP_CYC = 240,
  parameter int unsigned DRIVE_CYC = 600000
) (
  input  logic       clk,
  input  logic       rst_n,
  output pin_phase_e phase,
  output logic       strap_tick,
  output logic       drive_tick
);
  localparam int unsigned CW = $clog2(DRIVE_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt < CW'(DRIVE_CYC)) cnt <= cnt + 1'b1;
  end

  always_comb begin
    if (cnt < CW'(STRAP_CYC))      phase = PH_STRAP;
    else if (cnt < CW'(DRIVE_CYC)) phase = PH_HOLD;
    else                           phase = PH_DRIVE;
  end

  assign strap_tick = (cnt == CW'(STRAP_CYC - 1));
  assign drive_tick = (cnt == CW'(DRIVE_CYC - 1));

  // R5: once the drive phase is reached the counter stays saturated
  a_r5_timer_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DRIVE) |=> (phase == PH_DRIVE));
  // R2: the strap moment lies inside the strap phase
  a_r2_tick_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    strap_tick |-> (phase == PH_STRAP));
endmodule

// File: rtl/strap_sync2.sv
module strap_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      q  <= 1'b0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/strap_pin_ctrl.sv
module strap_pin_ctrl
  import strap_pin_pkg::*;
#(
  parameter int unsigned CLK_KHZ  = 12000,
  parameter int unsigned STRAP_US = 20,
  parameter int unsigned DRIVE_US = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pad_in,
  input  logic suspend_i,
  output logic pad_oe,
  output logic pad_out,
  output logic gang_mode
);
  localparam int unsigned STRAP_CYC = us_to_cycles(CLK_KHZ, STRAP_US);
  localparam int unsigned DRIVE_CYC = us_to_cycles(CLK_KHZ, DRIVE_US);

  pin_phase_e phase;
  logic       strap_tick;
  logic       drive_tick;
  logic       pad_sync;
  logic       locked;
  logic       drive_en;

  strap_phase_timer #(
    .STRAP_CYC(STRAP_CYC),
    .DRIVE_CYC(DRIVE_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .strap_tick(strap_tick),
    .drive_tick(drive_tick)
  );

  strap_sync2 u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in),
    .q    (pad_sync)
  );

  // strap latch: written once per reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gang_mode <= 1'b0;
      locked    <= 1'b0;
    end else if (strap_tick && !locked) begin
      gang_mode <= pad_sync;
      locked    <= 1'b1;
    end
  end

  assign drive_en = pad_oe | drive_tick;

  // pad driver: gang -> flag equals suspend, individual -> inverted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_oe  <= 1'b0;
      pad_out <= 1'b0;
    end else begin
      pad_oe  <= drive_en;
      pad_out <= drive_en & ~(suspend_i ^ gang_mode);
    end
  end

  // R1: outputs quiet while reset is held
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!pad_oe && !pad_out && !gang_mode));
  // R4: latched mode never moves after lock
  a_r4_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(gang_mode));
  // R3: mode lock matches leaving the strap phase
  a_r3_lock_phase: assert property (@(posedge clk) disable iff (!rst_n)
    locked == (phase != PH_STRAP));
  // R5: driver enabled exactly in the drive phase
  a_r5_oe_phase: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe == (phase == PH_DRIVE));
  // R6: no drive value while pad is an input
  a_r6_out_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pad_oe |-> !pad_out);
  // R7 and R8: polarity follows the strap
  a_r7_flag_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe && $past(pad_oe)) |-> (pad_out == ($past(suspend_i) == gang_mode)));
endmodule

// File: tb/tb_strap_pin_ctrl.sv
module tb_strap_pin_ctrl;
  localparam int PER       = 10;
  localparam int CLK_KHZ   = 1000;
  localparam int STRAP_US  = 20;
  localparam int DRIVE_US  = 60;
  localparam int STRAP_CYC = CLK_KHZ * STRAP_US / 1000;
  localparam int DRIVE_CYC = CLK_KHZ * DRIVE_US / 1000;

  logic clk = 1'b0;
  logic rst_n;
  logic pad_in;
  logic suspend_i;
  logic pad_oe, pad_out, gang_mode;

  int total = 0;
  int bad   = 0;

  strap_pin_ctrl #(.CLK_KHZ(CLK_KHZ), .STRAP_US(STRAP_US), .DRIVE_US(DRIVE_US)) dut (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .suspend_i(suspend_i),
    .pad_oe(pad_oe), .pad_out(pad_out), .gang_mode(gang_mode)
  );

  always #(PER/2) clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #(PER/4);
  endtask

  // enter reset, then release just after a falling edge
  task automatic restart(input logic strap);
    rst_n = 1'b0;
    pad_in = strap;
    suspend_i = 1'b0;
    #(PER/4);
    chk("R1 oe", pad_oe, 1'b0);
    chk("R1 out", pad_out, 1'b0);
    chk("R1 mode", gang_mode, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic suspend_sweep(input logic g);
    for (int pat = 0; pat < 16; pat++) begin
      for (int b = 0; b < 4; b++) begin
        suspend_i = pat[b];
        step(1);
        if (g) chk("R7 gang flag", pad_out, pat[b]);
        else   chk("R8 individual flag", pad_out, ~pat[b]);
        chk("R5 oe held", pad_oe, 1'b1);
      end
    end
  endtask

  initial begin
    #(PER * 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < 2; s++) begin
      restart(s[0]);
      step(STRAP_CYC - 1);
      chk("R3 before latch", gang_mode, 1'b0);
      step(1);
      chk("R3 latched mode", gang_mode, s[0]);
      pad_in = ~s[0];
      step(5);
      chk("R4 pad toggle ignored", gang_mode, s[0]);
      step(DRIVE_CYC - STRAP_CYC - 6);
      chk("R5 oe one edge early", pad_oe, 1'b0);
      chk("R6 out while input", pad_out, 1'b0);
      step(1);
      chk("R5 oe at drive edge", pad_oe, 1'b1);
      suspend_sweep(s[0]);
      pad_in = s[0];
      step(3);
      chk("R4 mode after drive", gang_mode, s[0]);
    end

    // R2: early levels in the window do not count
    restart(1'b1);
    step(5);
    pad_in = 1'b0;
    step(STRAP_CYC - 5);
    chk("R2 early level ignored", gang_mode, 1'b0);

    // R2: flip after edge STRAP_CYC-3 is seen
    restart(1'b0);
    step(STRAP_CYC - 3);
    pad_in = 1'b1;
    step(3);
    chk("R2 flip before sample point", gang_mode, 1'b1);

    // R2: flip after edge STRAP_CYC-2 is too late
    restart(1'b0);
    step(STRAP_CYC - 2);
    pad_in = 1'b1;
    step(2);
    chk("R2 flip after sample point", gang_mode, 1'b0);

    // R9: reset during drive, then restrap the other way
    restart(1'b1);
    step(DRIVE_CYC + 2);
    chk("R9 driving before reset", pad_oe, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 oe drops in reset", pad_oe, 1'b0);
    chk("R9 mode cleared", gang_mode, 1'b0);
    restart(1'b0);
    step(DRIVE_CYC);
    chk("R9 restrapped mode", gang_mode, 1'b0);
    chk("R9 oe again", pad_oe, 1'b1);
    suspend_i = 1'b1;
    step(1);
    chk("R9 individual after restrap", pad_out, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule